// File: doc/BRIEF.md
# Two-level IO address translator

This block turns 32-bit device bus addresses into physical addresses with 4 KiB pages. The first translation level is held on chip in 64 registers. Each register covers a 32 MiB slice of bus space and points at a second-level table in memory. The second level is a table of 32-bit entries, and the block fetches them through a simple request/acknowledge read port. A small fully associative TLB keeps finished translations, so a repeated page is answered in one cycle without any memory traffic.

Software sets the block up through a word-wide register write port. The port holds the first-level registers, a translation-enable command bit, a two-bit window-size code and a TLB invalidate register. Writing a value V to the invalidate register removes every cached page whose bus address, shifted right by 14, equals V. A requester offers one address at a time with `req_valid`. The block answers with a one-cycle `rsp_valid` pulse that carries either a physical address or a fault flag. `req_ready` is low while a table walk is outstanding.

Register offsets on `cfg_addr`:

| Offset | Register |
|---|---|
| 0x000 + 4·i | First-level entry i, for i from 0 to 63 |
| 0x100 | Command register. Bit 8 enables translation. |
| 0x104 | Window-size code, bits 1:0 |
| 0x108 | TLB invalidate register, write only |

A write to any other offset has no effect.

Top module: `xlat_unit`

## Requirements
- R1: While bit 8 of the command register at offset 0x100 is clear, an accepted address is returned unchanged and zero-extended, with no fault, one cycle after acceptance and without a memory read.
- R2: The window code at offset 0x104 selects which addresses are translated: code 0 covers addresses whose bits 31:28 are zero, code 1 covers addresses whose bit 31 is zero, code 3 covers every address and code 2 covers none. An address outside the window passes through as in R1, even when its page is cached.
- R3: The first-level entry used is the one at offset 4·i, where i is bus address bits 30:25, whatever the window. The second-level entry is read from (entry bits PPN_W-1:0 shifted left by 12) plus 4 times bus address bits 24:12.
- R4: If the selected first-level entry has bit 30 clear (not valid) or bit 31 set (big-page type), the block returns a fault one cycle after acceptance and makes no memory read.
- R5: A fetched second-level entry with bit 31 set gives the physical address {entry bits PPN_W-1:0, bus address bits 11:0}. This response comes the cycle after `mem_ack`. The cached flag in bit 30 does not change the result.
- R6: A fetched second-level entry with bit 31 clear gives a fault and is not cached, so the next access to that page reads memory again.
- R7: A page that was translated before and is still cached is answered one cycle after acceptance with the cached physical address, without a memory read.
- R8: The TLB holds 8 pages and replaces them in round-robin order. After eight consecutive fills, a ninth fill evicts the first of the eight, and the other seven stay cached.
- R9: A write of V to offset 0x108 removes every cached page whose bus address shifted right by 14 equals V. Pages whose key differs stay cached.
- R10: A miss makes exactly one read. `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_ack` is high, and `req_ready` is low from acceptance of the miss until its response.
- R11: After reset, every first-level entry is invalid, translation is disabled, the window code is 0, the TLB is empty, `rsp_valid` and `mem_req` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Response is a translation fault |
| rsp_paddr | output | PPN_W+12 | Physical address |
| mem_req | output | 1 | Second-level read request |
| mem_addr | output | PPN_W+12 | Physical byte address of the entry |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Second-level entry |

## Verification
The bench goes after the places where a plausible design slips. It caches a faulting walk, which would turn a repeated fault into a silent translation to a garbage page. It gets the invalidate key off by a bit, which would either spare a stale page or wipe the wrong one. Because it replaces a cached page while leaving its neighbours alone, a wrong replacement order would show up as the wrong page missing. It also checks the window edges and the reserved code, where a wrong decode would translate an address that should pass through. It checks that a page held in the TLB is still bypassed when the window or the enable excludes it. Finally it checks that a big-page first-level entry faults without a read, rather than being walked like a table pointer.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W     = 32;
    localparam int PG_SH    = 12;
    localparam int VPN_W    = VA_W - PG_SH;
    localparam int L1_CNT   = 64;
    localparam int L1_IW    = 6;
    localparam int L2_IW    = 13;
    localparam int CFG_AW   = 9;
    localparam int INV_SH   = 14;
    localparam int CMD_EN_BIT = 8;

    localparam logic [CFG_AW-1:0] OFF_CMD = 9'h100;
    localparam logic [CFG_AW-1:0] OFF_WIN = 9'h104;
    localparam logic [CFG_AW-1:0] OFF_INV = 9'h108;

    typedef struct packed {
        logic        big;
        logic        vld;
        logic [29:0] base;
    } l1e_t;

    typedef struct packed {
        logic        vld;
        logic        cached;
        logic [29:0] rpn;
    } l2e_t;

    typedef enum logic [1:0] {
        WIN_256M = 2'd0,
        WIN_2G   = 2'd1,
        WIN_NONE = 2'd2,
        WIN_ALL  = 2'd3
    } win_e;

    typedef enum logic {
        ST_IDLE,
        ST_READ
    } walk_e;

    function automatic logic in_window(input logic [VA_W-1:0] a, input win_e w);
        case (w)
            WIN_256M: return a[31:28] == 4'd0;
            WIN_2G:   return !a[31];
            WIN_ALL:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [L1_IW-1:0] l1_idx(input logic [VA_W-1:0] a);
        return a[30:25];
    endfunction

    function automatic logic [L2_IW-1:0] l2_idx(input logic [VA_W-1:0] a);
        return a[24:12];
    endfunction

    function automatic logic [31:0] inv_key(input logic [VPN_W-1:0] vpn);
        return 32'(vpn >> (INV_SH - PG_SH));
    endfunction

endpackage

// File: rtl/xlat_cfg.sv
module xlat_cfg
    import xlat_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [CFG_AW-1:0]       addr,
    input  logic [31:0]             wdata,
    input  logic [L1_IW-1:0]        rd_idx,
    output l1e_t                    rd_entry,
    output logic                    xl_en,
    output win_e                    win,
    output logic                    inv_en,
    output logic [31:0]             inv_val
);

    l1e_t l1_q [L1_CNT];

    logic l1_sel;
    assign l1_sel = we && !addr[8] && (addr[1:0] == 2'b00);

    for (genvar i = 0; i < L1_CNT; i++) begin : g_l1
        always_ff @(posedge clk) begin
            if (rst) begin
                l1_q[i] <= '0;
            end else if (l1_sel && addr[7:2] == L1_IW'(i)) begin
                l1_q[i] <= l1e_t'(wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_en <= 1'b0;
            win   <= WIN_256M;
        end else if (we) begin
            if (addr == OFF_CMD) xl_en <= wdata[CMD_EN_BIT];
            if (addr == OFF_WIN) win   <= win_e'(wdata[1:0]);
        end
    end

    assign rd_entry = l1_q[rd_idx];
    assign inv_en   = we && (addr == OFF_INV);
    assign inv_val  = wdata;

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int N     = 8,
    parameter int PPN_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [VPN_W-1:0]    lk_vpn,
    output logic                hit,
    output logic [PPN_W-1:0]    hit_ppn,
    output logic [N-1:0]        hit_vec,
    input  logic                fill_en,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic                inv_en,
    input  logic [31:0]         inv_val
);

    localparam int RR_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     vld_q;
    logic [VPN_W-1:0] tag_q [N];
    logic [PPN_W-1:0] ppn_q [N];
    logic [RR_W-1:0]  rr_q;
    logic             fill_killed;

    assign fill_killed = inv_en && (inv_key(fill_vpn) == inv_val);

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign hit_vec[i] = vld_q[i] && (tag_q[i] == lk_vpn);

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                ppn_q[i] <= '0;
            end else if (fill_en && rr_q == RR_W'(i)) begin
                vld_q[i] <= !fill_killed;
                tag_q[i] <= fill_vpn;
                ppn_q[i] <= fill_ppn;
            end else if (inv_en && inv_key(tag_q[i]) == inv_val) begin
                vld_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
        end
    end

    assign hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fill_en) begin
            rr_q <= (rr_q == RR_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
    import xlat_pkg::*;
#(
    parameter int PPN_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc,
    input  logic [VA_W-1:0]         req_addr,
    input  logic                    xl_en,
    input  win_e                    win,
    input  l1e_t                    l1,
    input  logic                    hit,
    input  logic [PPN_W-1:0]        hit_ppn,
    output logic                    req_ready,
    output logic                    mem_req,
    output logic [PPN_W+PG_SH-1:0]  mem_addr,
    input  logic                    mem_ack,
    input  logic [31:0]             mem_rdata,
    output logic                    rsp_valid,
    output logic                    rsp_fault,
    output logic [PPN_W+PG_SH-1:0]  rsp_paddr,
    output logic                    fill_en,
    output logic [VPN_W-1:0]        fill_vpn,
    output logic [PPN_W-1:0]        fill_ppn
);

    localparam int PA_W = PPN_W + PG_SH;

    walk_e           st_q;
    logic [VA_W-1:0] va_q;
    l2e_t            l2;
    logic            xlate;

    assign l2        = l2e_t'(mem_rdata);
    assign xlate     = xl_en && in_window(req_addr, win);
    assign req_ready = (st_q == ST_IDLE);

    assign fill_en  = (st_q == ST_READ) && mem_ack && l2.vld;
    assign fill_vpn = va_q[VA_W-1:PG_SH];
    assign fill_ppn = l2.rpn[PPN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            va_q      <= '0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (acc) begin
                        if (!xlate) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_paddr <= PA_W'(req_addr);
                        end else if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_paddr <= {hit_ppn, req_addr[PG_SH-1:0]};
                        end else if (!l1.vld || l1.big) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b1;
                            rsp_paddr <= '0;
                        end else begin
                            st_q     <= ST_READ;
                            va_q     <= req_addr;
                            mem_req  <= 1'b1;
                            mem_addr <= {l1.base[PPN_W-1:0], {PG_SH{1'b0}}}
                                        + PA_W'({l2_idx(req_addr), 2'b00});
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        st_q      <= ST_IDLE;
                        mem_req   <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_fault <= !l2.vld;
                        rsp_paddr <= l2.vld ? {l2.rpn[PPN_W-1:0], va_q[PG_SH-1:0]} : '0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int PPN_W = 24,
    parameter int TLB_N = 8,
    localparam int PA_W = PPN_W + PG_SH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_addr,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic                mem_req,
    output logic [PA_W-1:0]     mem_addr,
    input  logic                mem_ack,
    input  logic [31:0]         mem_rdata
);

    l1e_t              l1_ent;
    logic              xl_en;
    win_e              win;
    logic              inv_en;
    logic [31:0]       inv_val;
    logic              hit;
    logic [PPN_W-1:0]  hit_ppn;
    logic [TLB_N-1:0]  hit_vec;
    logic              fill_en;
    logic [VPN_W-1:0]  fill_vpn;
    logic [PPN_W-1:0]  fill_ppn;
    logic              acc;

    assign acc = req_valid && req_ready;

    xlat_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rd_idx   (l1_idx(req_addr)),
        .rd_entry (l1_ent),
        .xl_en    (xl_en),
        .win      (win),
        .inv_en   (inv_en),
        .inv_val  (inv_val)
    );

    xlat_tlb #(.N(TLB_N), .PPN_W(PPN_W)) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .lk_vpn   (req_addr[VA_W-1:PG_SH]),
        .hit      (hit),
        .hit_ppn  (hit_ppn),
        .hit_vec  (hit_vec),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .inv_en   (inv_en),
        .inv_val  (inv_val)
    );

    xlat_walk #(.PPN_W(PPN_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .req_addr  (req_addr),
        .xl_en     (xl_en),
        .win       (win),
        .l1        (l1_ent),
        .hit       (hit),
        .hit_ppn   (hit_ppn),
        .req_ready (req_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_paddr (rsp_paddr),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn)
    );

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
    parameter int PA_W  = 36,
    parameter int TLB_N = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_addr,
    input logic             xl_en,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [PA_W-1:0]  mem_addr,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [TLB_N-1:0] hit_vec
);

    assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !xl_en) |=>
            (rsp_valid && !rsp_fault && rsp_paddr[31:0] == $past(req_addr)
             && (rsp_paddr >> 32) == '0));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    assert_unique_hit_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_rsp_cause_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_ack)));

endmodule

bind xlat_unit xlat_chk #(.PA_W(PA_W), .TLB_N(TLB_N)) u_chk (.*);

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;

    localparam int PA_W = 36;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [8:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [31:0]     req_addr = '0;
    logic            rsp_valid;
    logic            rsp_fault;
    logic [PA_W-1:0] rsp_paddr;
    logic            mem_req;
    logic [PA_W-1:0] mem_addr;
    logic            mem_ack;
    logic [31:0]     mem_rdata;

    always #5 clk = ~clk;

    xlat_unit u0 (.*);

    logic [31:0]     mem [0:16383];
    logic            busy;
    int              dly;
    logic [PA_W-1:0] last_addr;
    int              reads;
    int              n_chk = 0;
    int              n_bad = 0;

    always @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            dly       <= 0;
            reads     <= 0;
            last_addr <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (busy) begin
            if (dly == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[last_addr[15:2]];
                busy      <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end else if (mem_req) begin
            busy      <= 1'b1;
            dly       <= 1;
            last_addr <= mem_addr;
            reads     <= reads + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] a, output logic [PA_W-1:0] pa,
                          output logic f, output int lat, output logic rdy1);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        rdy1 = req_ready;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        pa = rsp_paddr;
        f  = rsp_fault;
    endtask

    logic [PA_W-1:0] pa;
    logic            f;
    logic            rdy1;
    int              lat;
    int              r0;

    task automatic t_reset();
        chk("R11 rsp_valid", rsp_valid, 0);
        chk("R11 mem_req", mem_req, 0);
        chk("R11 req_ready", req_ready, 1);
    endtask

    task automatic t_bypass();
        r0 = reads;
        do_req(32'h1234_5678, pa, f, lat, rdy1);
        chk("R1 paddr", pa, 36'h0_1234_5678);
        chk("R1 fault", f, 0);
        chk("R1 latency", lat, 1);
        chk("R1 no read", reads - r0, 0);
        cfg_wr(9'h100, 32'h100);
        r0 = reads;
        do_req(32'h0000_3abc, pa, f, lat, rdy1);
        chk("R11 L1 invalid after reset", f, 1);
        chk("R11 no read", reads - r0, 0);
        cfg_wr(9'h104, 32'h1);
    endtask

    task automatic t_miss_hit();
        cfg_wr(9'h000, 32'h4000_0001);
        mem[14'h403] = 32'h800A_BCDE;
        r0 = reads;
        do_req(32'h0000_3abc, pa, f, lat, rdy1);
        chk("R5 paddr", pa, 36'h0_ABCD_EABC);
        chk("R5 fault", f, 0);
        chk("R3 walk address", last_addr, 36'h0_0000_100C);
        chk("R10 one read", reads - r0, 1);
        chk("R10 ready low during walk", rdy1, 0);
        r0 = reads;
        do_req(32'h0000_3123, pa, f, lat, rdy1);
        chk("R7 hit paddr", pa, 36'h0_ABCD_E123);
        chk("R7 hit latency", lat, 1);
        chk("R7 no read", reads - r0, 0);
    endtask

    task automatic t_l1_fault();
        r0 = reads;
        do_req(32'h0200_0000, pa, f, lat, rdy1);
        chk("R4 invalid L1 fault", f, 1);
        chk("R4 latency", lat, 1);
        cfg_wr(9'h008, 32'hC000_0001);
        do_req(32'h0400_0000, pa, f, lat, rdy1);
        chk("R4 big-page fault", f, 1);
        chk("R4 no read", reads - r0, 0);
    endtask

    task automatic t_l2_fault();
        mem[14'h405] = 32'h0000_0077;
        r0 = reads;
        do_req(32'h0000_5000, pa, f, lat, rdy1);
        chk("R6 fault", f, 1);
        do_req(32'h0000_5000, pa, f, lat, rdy1);
        chk("R6 fault again", f, 1);
        chk("R6 re-read", reads - r0, 2);
        mem[14'h405] = 32'hC000_0077;
        do_req(32'h0000_5010, pa, f, lat, rdy1);
        chk("R5 cached flag ignored", pa, 36'h0_0007_7010);
        chk("R6 read after fix", reads - r0, 3);
    endtask

    task automatic t_inval();
        cfg_wr(9'h108, 32'h1);
        r0 = reads;
        do_req(32'h0000_3abc, pa, f, lat, rdy1);
        chk("R9 other key kept", reads - r0, 0);
        chk("R9 paddr", pa, 36'h0_ABCD_EABC);
        cfg_wr(9'h108, 32'h0);
        do_req(32'h0000_3abc, pa, f, lat, rdy1);
        chk("R9 matching key removed", reads - r0, 1);
        chk("R9 refilled paddr", pa, 36'h0_ABCD_EABC);
    endtask

    task automatic t_window();
        r0 = reads;
        do_req(32'h8000_1000, pa, f, lat, rdy1);
        chk("R2 2G outside passes", pa, 36'h0_8000_1000);
        cfg_wr(9'h104, 32'h0);
        do_req(32'h1000_3abc, pa, f, lat, rdy1);
        chk("R2 256M outside passes", pa, 36'h0_1000_3abc);
        do_req(32'h0000_3abc, pa, f, lat, rdy1);
        chk("R2 256M inside translates", pa, 36'h0_ABCD_EABC);
        chk("R2 no reads", reads - r0, 0);
        cfg_wr(9'h104, 32'h3);
        do_req(32'h8000_3abc, pa, f, lat, rdy1);
        chk("R3 bit31 ignored in index", pa, 36'h0_ABCD_EABC);
        chk("R2 all window read", reads - r0, 1);
        cfg_wr(9'h104, 32'h2);
        do_req(32'h0000_3abc, pa, f, lat, rdy1);
        chk("R2 empty window passes cached page", pa, 36'h0_0000_3abc);
        cfg_wr(9'h104, 32'h1);
    endtask

    task automatic t_rr();
        cfg_wr(9'h00C, 32'h4000_0004);
        for (int k = 0; k < 9; k++) mem[14'h1000 + k] = 32'h8000_0100 + k;
        r0 = reads;
        for (int k = 0; k < 9; k++) begin
            do_req(32'h0600_0000 + (k << 12), pa, f, lat, rdy1);
            chk("R8 fill paddr", pa, 36'((256 + k) << 12));
        end
        chk("R8 nine reads", reads - r0, 9);
        r0 = reads;
        do_req(32'h0600_1000, pa, f, lat, rdy1);
        chk("R8 second page kept", reads - r0, 0);
        do_req(32'h0600_8000, pa, f, lat, rdy1);
        chk("R8 newest page kept", reads - r0, 0);
        do_req(32'h0600_0000, pa, f, lat, rdy1);
        chk("R8 oldest page evicted", reads - r0, 1);
        chk("R8 refill paddr", pa, 36'h0_0010_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16384; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_miss_hit();
        t_l1_fault();
        t_l2_fault();
        t_inval();
        t_window();
        t_rr();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule